// File: doc/BRIEF.md
# Partial-Beat Write Strober and Read Trimmer

This block sits on the data path of a DMA engine, between a narrow streaming port and a wider memory-mapped data bus. It lets a transfer length be a multiple of the narrow stream width instead of the full bus width. The last bus beat of a transfer may therefore be only partly valid.

For a write, every beat passes through unchanged. The byte strobes of the last beat are cleared for the bytes that lie past the end of the transfer. For a read, a whole beat is always taken from memory. The bytes past the end are then forced to zero, and the strobe vector marks which bytes the stream side should keep. The block checks the configuration at the start of each transfer. It refuses a start address that is not aligned to the bus width, and a length that is not a whole number of stream words.

A transfer begins with a one-cycle start pulse that carries the direction, the length in bytes minus one, and the low address bits that give the offset inside a bus word. Beats then flow in and out with valid/ready handshakes, and a last flag marks the final beat.

Top module: `pbeat_trim`

## Requirements
- R1: A length whose byte count (cfg_len + 1) is not a multiple of STREAM_BYTES (2 by default) is a configuration error.
- R2: A nonzero start-address offset (cfg_addr_ofs, the address bits below the bus width) is a configuration error.
- R3: cfg_err is valid from the first clock edge after an accepted start pulse and holds until the next accepted start. While it is set, in_ready stays low and no beat is accepted.
- R4: An error-free transfer takes exactly cfg_len / BUS_BYTES + 1 beats (integer division). out_last is set on the final beat only, and in_ready is low once that beat has been taken.
- R5: Every beat except the last carries all strobe bits set.
- R6: On the last beat, strobe bit k (byte lane k, bits 8k+7..8k of the data) is set exactly when k <= cfg_len mod BUS_BYTES.
- R7: In write mode (cfg_dir = 0), out_data equals the accepted in_data on every beat.
- R8: In read mode (cfg_dir = 1), byte lanes whose strobe is clear are output as zero, and the other lanes equal in_data.
- R9: in_ready is high when a transfer is active and the output register is empty or being drained. While out_valid is high and out_ready is low, out_data, out_strb and out_last stay unchanged.
- R10: A start pulse that arrives while a transfer is still active is ignored and does not change cfg_err or the transfer.
- R11: After reset, out_valid, in_ready and cfg_err are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | One-cycle pulse that starts a transfer |
| cfg_dir | input | 1 | 0 = write (strobe), 1 = read (trim) |
| cfg_len | input | LEN_W | Transfer length in bytes minus one |
| cfg_addr_ofs | input | log2(BUS_BYTES) | Start address bits below the bus width |
| cfg_err | output | 1 | Configuration of the last accepted start was invalid |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 8*BUS_BYTES | Input beat data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 8*BUS_BYTES | Output data (trimmed in read mode) |
| out_strb | output | BUS_BYTES | Per-byte valid strobes |
| out_last | output | 1 | Final beat of the transfer |

## Verification
cfg_err is sampled at the falling edge after the start pulse has been registered, because it is registered on that clock edge. An input beat taken at a rising edge shows on out_data, out_strb and out_last from that same edge. The bench drives one beat per falling edge and checks the previous beat at the next falling edge. in_ready is combinational from the active state and the output register. The bench therefore reads it in the same half-cycle that it drives in_valid. Stall and ignored-start cases are checked over several held cycles before the block is released.

// File: rtl/pbeat_trim_pkg.sv
package pbeat_trim_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } trim_dir_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pbeat_cfg_check.sv
module pbeat_cfg_check #(
   parameter int BUS_BYTES    = 8,
   parameter int STREAM_BYTES = 2,
   parameter int LEN_W        = 16,
   localparam int OFS_W       = $clog2(BUS_BYTES),
   localparam int SOFS_W      = $clog2(STREAM_BYTES),
   localparam int CNT_W       = LEN_W - OFS_W
) (
   input  logic [LEN_W-1:0] len,
   input  logic [OFS_W-1:0] addr_ofs,
   output logic             cfg_bad,
   output logic [CNT_W-1:0] last_idx,
   output logic [OFS_W-1:0] tail
);

   logic len_bad;
   logic addr_bad;

   generate
      if (SOFS_W == 0) begin : g_byte_stream
         assign len_bad = 1'b0;
      end else begin : g_word_stream
         assign len_bad = ~&len[SOFS_W-1:0];
      end
   endgenerate

   assign addr_bad = |addr_ofs;
   assign cfg_bad  = len_bad | addr_bad;
   assign last_idx = len[LEN_W-1:OFS_W];
   assign tail     = len[OFS_W-1:0];

endmodule

// File: rtl/pbeat_mask_gen.sv
module pbeat_mask_gen #(
   parameter int BUS_BYTES    = 8,
   parameter int STREAM_BYTES = 2,
   localparam int OFS_W       = $clog2(BUS_BYTES)
) (
   input  logic [OFS_W-1:0]     tail,
   output logic [BUS_BYTES-1:0] mask
);

   generate
      if (STREAM_BYTES == BUS_BYTES) begin : g_whole_beat
         assign mask = '1;
      end else begin : g_partial
         for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
            localparam logic [OFS_W-1:0] LANE = OFS_W'(i);
            assign mask[i] = (LANE <= tail);
         end
      end
   endgenerate

endmodule

// File: rtl/pbeat_beat_ctr.sv
module pbeat_beat_ctr #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_idx,
   input  logic             step,
   output logic             active,
   output logic             is_last
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] remain_q;

   assign is_last = (remain_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
         active   <= 1'b0;
      end else if (load) begin
         remain_q <= load_idx;
         active   <= 1'b1;
      end else if (step) begin
         if (is_last) begin
            active <= 1'b0;
         end else begin
            remain_q <= remain_q - ONE;
         end
      end
   end

endmodule

// File: rtl/pbeat_out_stage.sv
module pbeat_out_stage
   import pbeat_trim_pkg::*;
#(
   parameter int BUS_BYTES = 8,
   localparam int DATA_W   = BUS_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  trim_dir_e            dir,
   input  logic [DATA_W-1:0]    beat_data,
   input  logic [BUS_BYTES-1:0] beat_strb,
   input  logic                 beat_last,
   input  logic                 drain,
   output logic                 valid,
   output logic [DATA_W-1:0]    data,
   output logic [BUS_BYTES-1:0] strb,
   output logic                 last
);

   logic [DATA_W-1:0] shaped;

   generate
      for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
         assign shaped[i*BYTE_W +: BYTE_W] =
            ((dir == DIR_READ) && !beat_strb[i]) ? '0 : beat_data[i*BYTE_W +: BYTE_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
         strb  <= '0;
         last  <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= shaped;
         strb  <= beat_strb;
         last  <= beat_last;
      end else if (drain) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/pbeat_trim.sv
module pbeat_trim
   import pbeat_trim_pkg::*;
#(
   parameter int BUS_BYTES    = 8,
   parameter int STREAM_BYTES = 2,
   parameter int LEN_W        = 16,
   localparam int OFS_W       = $clog2(BUS_BYTES),
   localparam int CNT_W       = LEN_W - OFS_W,
   localparam int DATA_W      = BUS_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_start,
   input  logic                 cfg_dir,
   input  logic [LEN_W-1:0]     cfg_len,
   input  logic [OFS_W-1:0]     cfg_addr_ofs,
   output logic                 cfg_err,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [DATA_W-1:0]    in_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [DATA_W-1:0]    out_data,
   output logic [BUS_BYTES-1:0] out_strb,
   output logic                 out_last
);

   initial begin
      assert (is_pow2(BUS_BYTES) && BUS_BYTES >= 2)
         else $error("BUS_BYTES must be a power of two, at least 2");
      assert (is_pow2(STREAM_BYTES) && STREAM_BYTES <= BUS_BYTES)
         else $error("STREAM_BYTES must be a power of two not above BUS_BYTES");
      assert (LEN_W > OFS_W)
         else $error("LEN_W must exceed the bus offset width");
   end

   logic                 cfg_bad;
   logic [CNT_W-1:0]     last_idx;
   logic [OFS_W-1:0]     tail;
   logic [BUS_BYTES-1:0] tail_mask;
   logic [BUS_BYTES-1:0] tail_mask_q;
   trim_dir_e            dir_q;
   logic                 err_q;
   logic                 xfer_active;
   logic                 beat_is_last;
   logic                 start_ok;
   logic                 accept;
   logic [BUS_BYTES-1:0] beat_strb;

   pbeat_cfg_check #(
      .BUS_BYTES    (BUS_BYTES),
      .STREAM_BYTES (STREAM_BYTES),
      .LEN_W        (LEN_W)
   ) i_cfg_check (
      .len      (cfg_len),
      .addr_ofs (cfg_addr_ofs),
      .cfg_bad  (cfg_bad),
      .last_idx (last_idx),
      .tail     (tail)
   );

   pbeat_mask_gen #(
      .BUS_BYTES    (BUS_BYTES),
      .STREAM_BYTES (STREAM_BYTES)
   ) i_mask_gen (
      .tail (tail),
      .mask (tail_mask)
   );

   assign start_ok = cfg_start && !xfer_active;
   assign in_ready = xfer_active && (!out_valid || out_ready);
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q       <= 1'b0;
         dir_q       <= DIR_WRITE;
         tail_mask_q <= '0;
      end else if (start_ok) begin
         err_q       <= cfg_bad;
         dir_q       <= trim_dir_e'(cfg_dir);
         tail_mask_q <= tail_mask;
      end
   end

   assign cfg_err = err_q;

   pbeat_beat_ctr #(
      .CNT_W (CNT_W)
   ) i_beat_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_ok && !cfg_bad),
      .load_idx (last_idx),
      .step     (accept),
      .active   (xfer_active),
      .is_last  (beat_is_last)
   );

   assign beat_strb = beat_is_last ? tail_mask_q : '1;

   pbeat_out_stage #(
      .BUS_BYTES (BUS_BYTES)
   ) i_out_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .dir       (dir_q),
      .beat_data (in_data),
      .beat_strb (beat_strb),
      .beat_last (beat_is_last),
      .drain     (out_ready),
      .valid     (out_valid),
      .data      (out_data),
      .strb      (out_strb),
      .last      (out_last)
   );

endmodule

// File: rtl/pbeat_trim_chk.sv
module pbeat_trim_chk
   import pbeat_trim_pkg::*;
#(
   parameter int BUS_BYTES = 8,
   localparam int DATA_W   = BUS_BYTES * BYTE_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_start,
   input logic                 cfg_err,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [DATA_W-1:0]    out_data,
   input logic [BUS_BYTES-1:0] out_strb,
   input logic                 out_last,
   input logic                 xfer_active,
   input trim_dir_e            dir_q
);

   localparam logic [BUS_BYTES-1:0] ONE = BUS_BYTES'(1);

   logic [DATA_W-1:0] lane_mask;

   generate
      for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
         assign lane_mask[i*BYTE_W +: BYTE_W] = {BYTE_W{out_strb[i]}};
      end
   endgenerate

   AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !in_ready);                                              // R3

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_active) |-> out_valid && out_last);                       // R4

   AST_FULL_STRB: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |-> &out_strb);                               // R5

   AST_STRB_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_strb[0] && (((out_strb + ONE) & out_strb) == '0)); // R6

   AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (dir_q == DIR_READ) |-> (out_data & ~lane_mask) == '0); // R8

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
                                  && $stable(out_strb) && $stable(out_last)); // R9

   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_active && cfg_start |=> $stable(cfg_err));                      // R10

endmodule

bind pbeat_trim pbeat_trim_chk #(
   .BUS_BYTES (BUS_BYTES)
) i_pbeat_trim_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_start   (cfg_start),
   .cfg_err     (cfg_err),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_data    (out_data),
   .out_strb    (out_strb),
   .out_last    (out_last),
   .xfer_active (xfer_active),
   .dir_q       (dir_q)
);

// File: tb/test_pbeat_trim.sv
`timescale 1ns/100ps
module test_pbeat_trim;

   localparam int BB    = 8;
   localparam int LW    = 16;
   localparam int OW    = 3;
   localparam int DW    = BB * 8;
   localparam int NVEC  = 11;

   // fields: {dir, len, addr offset, expected error}
   localparam logic [20:0] VEC [NVEC] = '{
      {1'b0, 16'd15, 3'd0, 1'b0},
      {1'b0, 16'd1,  3'd0, 1'b0},
      {1'b1, 16'd13, 3'd0, 1'b0},
      {1'b1, 16'd21, 3'd0, 1'b0},
      {1'b0, 16'd2,  3'd0, 1'b1},
      {1'b1, 16'd7,  3'd4, 1'b1},
      {1'b0, 16'd63, 3'd0, 1'b0},
      {1'b1, 16'd3,  3'd0, 1'b0},
      {1'b0, 16'd0,  3'd0, 1'b1},
      {1'b1, 16'd9,  3'd2, 1'b1},
      {1'b0, 16'd5,  3'd0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_start = 1'b0;
   logic          cfg_dir = 1'b0;
   logic [LW-1:0] cfg_len = '0;
   logic [OW-1:0] cfg_addr_ofs = '0;
   logic          cfg_err;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [DW-1:0] out_data;
   logic [BB-1:0] out_strb;
   logic          out_last;

   int  n_checks = 0;
   int  n_errs   = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   pbeat_trim #(
      .BUS_BYTES    (BB),
      .STREAM_BYTES (2),
      .LEN_W        (LW)
   ) i_pbeat_trim (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_start    (cfg_start),
      .cfg_dir      (cfg_dir),
      .cfg_len      (cfg_len),
      .cfg_addr_ofs (cfg_addr_ofs),
      .cfg_err      (cfg_err),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_data      (in_data),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_data     (out_data),
      .out_strb     (out_strb),
      .out_last     (out_last)
   );

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int b);
      return 64'hA1B2_C3D4_E5F6_0718 ^ (64'(b) * 64'h0101_0101_0101_0101);
   endfunction

   function automatic logic [BB-1:0] tail_mask(input logic [LW-1:0] len);
      logic [BB-1:0] m;
      for (int k = 0; k < BB; k++) m[k] = (k <= int'(len % BB));
      return m;
   endfunction

   function automatic logic [DW-1:0] lanes(input logic [BB-1:0] m);
      logic [DW-1:0] r;
      for (int k = 0; k < BB; k++) r[k*8 +: 8] = {8{m[k]}};
      return r;
   endfunction

   task automatic start(input logic dir, input logic [LW-1:0] len, input logic [OW-1:0] ofs);
      @(negedge clk);
      cfg_start    = 1'b1;
      cfg_dir      = dir;
      cfg_len      = len;
      cfg_addr_ofs = ofs;
      @(negedge clk);
      cfg_start = 1'b0;
   endtask

   task automatic run_beats(input logic dir, input logic [LW-1:0] len);
      int nb;
      logic [BB-1:0] es;
      logic [DW-1:0] ed;
      nb = int'(len / BB) + 1;
      chk(in_ready === 1'b1, "R9 ready at start", DW'(in_ready), DW'(1));
      for (int b = 0; b < nb; b++) begin
         in_data  = pat(b);
         in_valid = 1'b1;
         @(negedge clk);
         es = (b == nb - 1) ? tail_mask(len) : '1;
         ed = dir ? (pat(b) & lanes(es)) : pat(b);
         chk(out_valid === 1'b1, "R4 beat valid", DW'(out_valid), DW'(1));
         chk(out_strb === es, (b == nb - 1) ? "R6 last strobe" : "R5 full strobe",
             DW'(out_strb), DW'(es));
         chk(out_data === ed, dir ? "R8 read trim" : "R7 write pass", out_data, ed);
         chk(out_last === (b == nb - 1), "R4 last flag", DW'(out_last), DW'(b == nb - 1));
      end
      in_valid = 1'b0;
      chk(in_ready === 1'b0, "R4 no beat after last", DW'(in_ready), DW'(0));
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(out_valid === 1'b0, "R11 out_valid", DW'(out_valid), DW'(0));
      chk(in_ready === 1'b0, "R11 in_ready", DW'(in_ready), DW'(0));
      chk(cfg_err === 1'b0, "R11 cfg_err", DW'(cfg_err), DW'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R1 R2 R3 and the data path
      for (int v = 0; v < NVEC; v++) begin
         logic dir;
         logic [LW-1:0] len;
         logic [OW-1:0] ofs;
         logic err;
         {dir, len, ofs, err} = VEC[v];
         start(dir, len, ofs);
         chk(cfg_err === err, err ? "R1/R2 error flag" : "R3 error clear",
             DW'(cfg_err), DW'(err));
         if (err) begin
            chk(in_ready === 1'b0, "R3 blocked", DW'(in_ready), DW'(0));
         end else begin
            run_beats(dir, len);
         end
      end

      // R3: beats offered under an error are not taken
      start(1'b0, 16'd4, 3'd0);
      in_valid = 1'b1;
      in_data  = pat(5);
      repeat (2) @(negedge clk);
      chk(out_valid === 1'b0, "R3 no output under error", DW'(out_valid), DW'(0));
      chk(cfg_err === 1'b1, "R3 error held", DW'(cfg_err), DW'(1));
      in_valid = 1'b0;

      // R9: stall holds the output beat
      start(1'b0, 16'd15, 3'd0);
      out_ready = 1'b0;
      in_data   = pat(0);
      in_valid  = 1'b1;
      @(negedge clk);
      in_data = pat(1);
      chk(in_ready === 1'b0, "R9 ready low on stall", DW'(in_ready), DW'(0));
      repeat (2) @(negedge clk);
      chk(out_valid === 1'b1, "R9 held valid", DW'(out_valid), DW'(1));
      chk(out_data === pat(0), "R9 held data", out_data, pat(0));
      chk(out_last === 1'b0, "R9 held last", DW'(out_last), DW'(0));
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_data === pat(1), "R9 next beat", out_data, pat(1));
      chk(out_last === 1'b1, "R9 next beat last", DW'(out_last), DW'(1));
      @(negedge clk);
      chk(out_valid === 1'b0, "R9 drained", DW'(out_valid), DW'(0));

      // R10: start while active is ignored
      start(1'b0, 16'd15, 3'd0);
      start(1'b1, 16'd2, 3'd1);
      chk(cfg_err === 1'b0, "R10 error unchanged", DW'(cfg_err), DW'(0));
      run_beats(1'b0, 16'd15);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

endmodule